// File: doc/BRIEF.md
# Three-Wire SPI Master Frame Buffer Controller

This block runs the data path of a clock-synchronous SPI master that uses only three wires: a serial clock it drives, a data line it drives and a data line it samples. No select line is produced. A host stores words through a write port into a small transmit queue. When a full batch of the configured size has arrived, the words are handed one at a time to a shift register. Each word is clocked out most significant bit first while the input line is sampled, and the received word is then offered to the host in a single-entry receive register.

The host watches two flags. `tx_empty` says the queue is taking words for the next batch. `rx_full` says an unread received word is waiting. Clock polarity, clock phase, word length (8 to 16 bits), batch size (1 to 4 words) and the clock divider are static inputs. They are changed only while no frame is in progress. Received words that arrive while the receive register still holds unread data are dropped. The shift register's own busy state is never exposed.

Top module: `spi3w_xfer_ctrl`

## Requirements
- R1: While `tx_empty` is low, `wr_en` is ignored: the word is not stored and causes no extra frame, either now or in a later batch.
- R2: `cfg_frames` holds the batch size minus one (0..3 means 1..4 words). No `sclk` edge occurs until that many words have been accepted since the previous batch was handed over.
- R3: Each frame sends the low `cfg_len` bits (8..16) of the written word on `mosi`, the highest of those bits first. Bits of `wr_data` above `cfg_len` are never sent.
- R4: The `cfg_len` bits sampled from `miso` appear right-aligned on `rd_data`. The first sampled bit is at position `cfg_len`-1 and the bits above are zero.
- R5: `sclk` rests at `cfg_cpol` between frames. With `cfg_cpha`=0, `miso` is sampled on the leading edge of each bit and `mosi` changes on the trailing edge. With `cfg_cpha`=1, `mosi` changes on the leading edge (except the first) and sampling happens on the trailing edge. A frame has 2*`cfg_len` edges and leaves `sclk` at its idle level.
- R6: Each `sclk` half period within a frame lasts `cfg_div`+1 cycles of `clk`.
- R7: At the end of a frame, the received word is stored and `rx_full` is set only if `rx_full` was clear. Otherwise the word is discarded and `rd_data` keeps its value.
- R8: Asserting `rd_en` while `rx_full` is high clears `rx_full` on the next clock edge.
- R9: After reset, `tx_empty` is 1 and `rx_full` is 0. `tx_empty` falls once the last word of a batch is accepted. It rises again one cycle after the batch's last word enters the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cpol | input | 1 | Idle level of `sclk` |
| cfg_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| cfg_len | input | 5 | Word length in bits, 8..16 |
| cfg_frames | input | 2 | Batch size minus one |
| cfg_div | input | 8 | Half period of `sclk` minus one, in `clk` cycles |
| wr_en | input | 1 | Host write strobe for the transmit queue |
| wr_data | input | 16 | Word to send, right-aligned |
| tx_empty | output | 1 | Queue takes words for the next batch |
| rd_en | input | 1 | Host read strobe, releases the receive register |
| rd_data | output | 16 | Last stored received word, right-aligned |
| rx_full | output | 1 | Unread received word present |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The in-line properties assume the configuration inputs do not change while a batch is queued or a frame is running. They also assume `cfg_len` stays within 8..16. Under those conditions, the edge counter never passes the last edge and the divider count never passes `cfg_div`. The stimulus changes configuration only after every expected frame has been seen and `sclk` is idle. It uses only legal lengths. The serial slave model changes `miso` half a system cycle away from the edges the block samples on.

// File: rtl/spi3w_pkg.sv
// Package: shared types and helpers for the three-wire SPI master controller.
// Assumes nothing beyond standard SystemVerilog.
package spi3w_pkg;

    // Clock mode pair carried as one unit through the serial engine.
    typedef struct packed {
        logic cpol;
        logic cpha;
    } spi3w_mode_t;

    // True when this edge of the clock is a sampling edge for the given phase.
    function automatic logic spi3w_is_sample_edge(input spi3w_mode_t mode, input logic leading);
        return leading ^ mode.cpha;
    endfunction

endpackage

// File: rtl/spi3w_txbuf.sv
// Module: transmit queue with batch arming.
// Collects host words until the configured batch size is reached, then hands
// them to the shifter one at a time. Assumes DEPTH is a power of two and that
// the batch size does not change while words are queued.
module spi3w_txbuf #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PTR_W-1:0]  frames_m1,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tx_empty,
    input  logic              pop_ready,
    output logic              pop,
    output logic [DATA_W-1:0] pop_data
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr;
    logic [PTR_W-1:0]  rptr;
    logic [CNT_W-1:0]  count;
    logic              armed;
    logic [CNT_W-1:0]  frames_n;
    logic              push;

    // Decode batch size and the accept/hand-over strobes.
    always_comb begin
        frames_n = CNT_W'(frames_m1) + CNT_W'(1);
        push     = wr_en && !armed;
        pop      = armed && pop_ready;
        tx_empty = !armed;
        pop_data = mem[rptr];
    end

    // Queue storage, written only on accepted words.
    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wr_data;
    end

    // Pointer, fill count and batch-armed state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            armed <= 1'b0;
        end else begin
            if (push) wptr <= wptr + 1'b1;
            if (pop)  rptr <= rptr + 1'b1;
            if (push)     count <= count + 1'b1;
            else if (pop) count <= count - 1'b1;
            if (pop && count == CNT_W'(1))
                armed <= 1'b0;
            else if (push && (count + 1'b1) == frames_n)
                armed <= 1'b1;
        end
    end

    // R1: a write while the batch is armed leaves the queue fill untouched.
    a_r1_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && armed && !pop_ready) |=> (count == $past(count)));

    // R2: an armed batch always has words to hand over.
    a_r2_armed_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (count != '0));

endmodule

// File: rtl/spi3w_shifter.sv
// Module: serial engine with clock divider.
// Loads a right-aligned word, left-aligns it for MSB-first output, generates
// 2*len clock edges at div+1 cycles per half period and assembles the sampled
// bits right-aligned. Assumes len in 8..DATA_W and static mode/div/len while busy.
module spi3w_shifter
    import spi3w_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DIV_W  = 8,
    localparam int LEN_W  = $clog2(DATA_W + 1),
    localparam int EDGE_W = LEN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  spi3w_mode_t       mode,
    input  logic [LEN_W-1:0]  len,
    input  logic [DIV_W-1:0]  div,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              ready,
    output logic              done,
    output logic [DATA_W-1:0] done_data,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);

    logic              busy;
    logic              sclk_q;
    logic [DIV_W-1:0]  div_cnt;
    logic [EDGE_W-1:0] edge_cnt;
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] rx_next;
    logic [EDGE_W-1:0] last_idx;
    logic [LEN_W-1:0]  align_sh;
    logic              tick;
    logic              leading;
    logic              sample_now;
    logic              shift_now;

    // Edge timing and per-edge role decode.
    always_comb begin
        last_idx   = {len, 1'b0} - EDGE_W'(1);
        align_sh   = LEN_W'(DATA_W) - len;
        tick       = busy && (div_cnt == div);
        leading    = !edge_cnt[0];
        sample_now = tick && spi3w_is_sample_edge(mode, leading);
        shift_now  = tick && !spi3w_is_sample_edge(mode, leading)
                     && !(mode.cpha && edge_cnt == '0);
        rx_next    = sample_now ? {rx_sh[DATA_W-2:0], miso} : rx_sh;
        done       = tick && (edge_cnt == last_idx);
        done_data  = rx_next;
        ready      = !busy;
        sclk       = busy ? sclk_q : mode.cpol;
        mosi       = tx_sh[DATA_W-1];
    end

    // Frame state: load, divide, toggle, shift and sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            sclk_q   <= 1'b0;
            div_cnt  <= '0;
            edge_cnt <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
        end else if (load) begin
            busy     <= 1'b1;
            sclk_q   <= mode.cpol;
            div_cnt  <= '0;
            edge_cnt <= '0;
            tx_sh    <= load_data << align_sh;
            rx_sh    <= '0;
        end else if (busy) begin
            if (tick) begin
                div_cnt  <= '0;
                sclk_q   <= !sclk_q;
                edge_cnt <= edge_cnt + 1'b1;
                rx_sh    <= rx_next;
                if (shift_now) tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
                if (edge_cnt == last_idx) busy <= 1'b0;
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end

    // R6: the serial clock holds its level between divider ticks.
    a_r6_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable(sclk));

    // R6: the divider count never passes the programmed value.
    a_r6_div_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (div_cnt <= div));

    // R5: a frame never runs past its final edge.
    a_r5_edge_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (edge_cnt <= last_idx));

    // R5: after the last edge the clock is back at its idle level.
    a_r5_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && sclk == mode.cpol));

endmodule

// File: rtl/spi3w_rxbuf.sv
// Module: single-entry receive register.
// Stores a finished frame only when empty; a host read releases it.
// Assumes done is a one-cycle pulse.
module spi3w_rxbuf #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] done_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_full
);

    logic capture;

    // Capture only into an empty register.
    always_comb capture = done && !rx_full;

    // Hold the received word and the full flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            rx_full <= 1'b0;
        end else begin
            if (capture) rd_data <= done_data;
            if (capture)    rx_full <= 1'b1;
            else if (rd_en) rx_full <= 1'b0;
        end
    end

    // R8: a read of a full register empties it.
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rx_full) |=> !rx_full);

    // R7: a frame finishing while full does not alter the stored word.
    a_r7_drop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rx_full) |=> $stable(rd_data));

    // R7: a frame finishing while empty fills the register.
    a_r7_capture_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !rx_full) |=> rx_full);

endmodule

// File: rtl/spi3w_xfer_ctrl.sv
// Module: top of the three-wire SPI master transfer buffer controller.
// Joins the transmit queue, serial engine and receive register. Assumes the
// configuration inputs are static while any word is queued or in flight.
module spi3w_xfer_ctrl
    import spi3w_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4,
    parameter int DIV_W  = 8,
    localparam int LEN_W = $clog2(DATA_W + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [PTR_W-1:0]  cfg_frames,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tx_empty,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_full,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);

    spi3w_mode_t       mode;
    logic              sh_ready;
    logic              pop;
    logic [DATA_W-1:0] pop_data;
    logic              done;
    logic [DATA_W-1:0] done_data;

    // Bundle the clock mode inputs.
    always_comb mode = '{cpol: cfg_cpol, cpha: cfg_cpha};

    spi3w_txbuf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .frames_m1 (cfg_frames),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .tx_empty  (tx_empty),
        .pop_ready (sh_ready),
        .pop       (pop),
        .pop_data  (pop_data)
    );

    spi3w_shifter #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .len       (cfg_len),
        .div       (cfg_div),
        .load      (pop),
        .load_data (pop_data),
        .ready     (sh_ready),
        .done      (done),
        .done_data (done_data),
        .sclk      (sclk),
        .mosi      (mosi),
        .miso      (miso)
    );

    spi3w_rxbuf #(.DATA_W(DATA_W)) u_rxbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (done),
        .done_data (done_data),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .rx_full   (rx_full)
    );

    // R9: the queue reopens only as its last word enters the shifter.
    a_r9_reopen_on_handover: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_empty) |-> $past(pop));

endmodule

// File: tb/spi3w_xfer_ctrl_bench.sv
`timescale 1ns/1ps
module spi3w_xfer_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_cpol, cfg_cpha;
    logic [4:0]  cfg_len;
    logic [1:0]  cfg_frames;
    logic [7:0]  cfg_div;
    logic        wr_en, rd_en;
    logic [15:0] wr_data;
    logic [15:0] rd_data;
    logic        tx_empty, rx_full, sclk, mosi, miso;

    always #10 clk = ~clk;

    spi3w_xfer_ctrl u_spi3w_xfer_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_len(cfg_len), .cfg_frames(cfg_frames), .cfg_div(cfg_div),
        .wr_en(wr_en), .wr_data(wr_data), .tx_empty(tx_empty),
        .rd_en(rd_en), .rd_data(rd_data), .rx_full(rx_full),
        .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Scoreboard queues: words expected on mosi, words the slave will send.
    logic [15:0] exp_q[$];
    logic [15:0] slave_q[$];

    logic        prev_sclk;
    bit          leading;
    bit          rate_bad;
    int          edges = 0;
    int          since = 0;
    int          frames_seen = 0;
    int          len;
    logic [15:0] mosi_acc = '0;
    logic [15:0] s_word = '0;
    logic [15:0] msk;
    logic [15:0] exp_w;

    always_comb len = int'(cfg_len);

    // Monitor and slave model: runs between clock edges.
    always @(negedge clk) begin
        if (rst_n) begin
            since++;
            if (sclk !== prev_sclk) begin
                leading = (prev_sclk == cfg_cpol);
                if (edges > 0 && since != int'(cfg_div) + 1) rate_bad = 1;
                since = 0;
                if (leading ^ cfg_cpha) mosi_acc = {mosi_acc[14:0], mosi};
                if (cfg_cpha && leading) miso = s_word[len - 1 - edges / 2];
                if (!cfg_cpha && !leading && (edges + 1) / 2 < len)
                    miso = s_word[len - 1 - (edges + 1) / 2];
                edges++;
                prev_sclk = sclk;
                if (edges == 2 * len) begin
                    msk = 16'hFFFF >> (16 - len);
                    if (exp_q.size() > 0) exp_w = exp_q.pop_front();
                    else exp_w = 16'hDEAD;
                    chk((mosi_acc & msk) == exp_w, "R3", "mosi word",
                        int'(mosi_acc & msk), int'(exp_w));
                    chk(!rate_bad, "R6", "half period", int'(rate_bad), 0);
                    rate_bad = 0;
                    frames_seen++;
                    edges = 0;
                    mosi_acc = '0;
                    s_word = (slave_q.size() > 0) ? slave_q.pop_front() : 16'h0;
                    if (!cfg_cpha) miso = s_word[len - 1];
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic configure(input logic pol, input logic pha, input int l,
                             input int dv, input int fm1);
        cfg_cpol = pol; cfg_cpha = pha; cfg_len = 5'(l);
        cfg_div = 8'(dv); cfg_frames = 2'(fm1);
        #1;
        prev_sclk = sclk;
        edges = 0; rate_bad = 0; mosi_acc = '0;
    endtask

    // Driver: queue expected mosi word and the slave's reply word.
    task automatic expect_frame(input logic [15:0] tx, input logic [15:0] rx);
        exp_q.push_back(tx & (16'hFFFF >> (16 - len)));
        slave_q.push_back(rx);
    endtask

    task automatic slave_prime();
        s_word = slave_q.pop_front();
        miso = cfg_cpha ? 1'b0 : s_word[len - 1];
    endtask

    task automatic host_write(input logic [15:0] d);
        wr_en = 1'b1; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic host_read(output logic [15:0] d);
        d = rd_data;
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic wait_frames(input int n, input string req);
        int target;
        int t;
        target = frames_seen + n;
        t = 0;
        while (frames_seen < target && t < 20000) begin
            tick();
            t++;
        end
        chk(frames_seen >= target, req, "frames completed", frames_seen, target);
    endtask

    task automatic summary();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
            summary();
        end
    end

    initial begin
        logic [15:0] rd;
        int f0;
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0; miso = 1'b0;
        configure(1'b0, 1'b0, 8, 1, 0);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R9 reset state, R5 idle level
        chk(tx_empty == 1'b1, "R9", "tx_empty after reset", tx_empty, 1);
        chk(rx_full == 1'b0, "R9", "rx_full after reset", rx_full, 0);
        chk(sclk == 1'b0, "R5", "idle sclk cpol0", sclk, 0);

        // Test A: mode 0, 8 bits, batch of one
        configure(1'b0, 1'b0, 8, 1, 0);
        expect_frame(16'h00A5, 16'h003C);
        slave_prime();
        host_write(16'h00A5);
        chk(tx_empty == 1'b0, "R9", "tx_empty low after batch", tx_empty, 0);
        tick();
        chk(tx_empty == 1'b1, "R9", "tx_empty back after handover", tx_empty, 1);
        wait_frames(1, "R2");
        tick();
        chk(rx_full == 1'b1, "R7", "capture into empty", rx_full, 1);
        host_read(rd);
        chk(rd == 16'h003C, "R4", "rx word mode0 len8", rd, 16'h003C);
        chk(rx_full == 1'b0, "R8", "read clears rx_full", rx_full, 0);

        // Test B: cpol1 cpha1, 12 bits, batch of three, drop and ignored write
        configure(1'b1, 1'b1, 12, 2, 2);
        expect_frame(16'h0123, 16'h09C3);
        expect_frame(16'h0ABC, 16'h00F0);
        expect_frame(16'h05A5, 16'h0777);
        slave_prime();
        f0 = frames_seen;
        host_write(16'h0123);
        host_write(16'h0ABC);
        repeat (40) tick();
        chk(frames_seen == f0, "R2", "no frame before batch complete", frames_seen, f0);
        chk(sclk == 1'b1, "R5", "idle sclk cpol1", sclk, 1);
        chk(tx_empty == 1'b1, "R2", "still accepting", tx_empty, 1);
        host_write(16'h05A5);
        chk(tx_empty == 1'b0, "R9", "tx_empty low on full batch", tx_empty, 0);
        host_write(16'h0FFF);
        wait_frames(3, "R2");
        repeat (10) tick();
        chk(frames_seen == f0 + 3, "R1", "no extra frame", frames_seen, f0 + 3);
        chk(tx_empty == 1'b1, "R9", "tx_empty after batch", tx_empty, 1);
        chk(rx_full == 1'b1, "R7", "first word held", rx_full, 1);
        host_read(rd);
        chk(rd == 16'h09C3, "R7", "later frames dropped", rd, 16'h09C3);
        chk(rx_full == 1'b0, "R8", "cleared after read", rx_full, 0);

        // R1: ignored word must not count toward the next batch
        expect_frame(16'h0001, 16'h0111);
        expect_frame(16'h0002, 16'h0222);
        expect_frame(16'h0003, 16'h0333);
        slave_prime();
        f0 = frames_seen;
        host_write(16'h0001);
        host_write(16'h0002);
        repeat (40) tick();
        chk(frames_seen == f0, "R1", "ignored word not queued", frames_seen, f0);
        host_write(16'h0003);
        wait_frames(3, "R2");
        tick();
        host_read(rd);
        chk(rd == 16'h0111, "R4", "rx word cpha1 len12", rd, 16'h0111);

        // Test C: cpol0 cpha1, 16 bits, divider 0, batch of four
        configure(1'b0, 1'b1, 16, 0, 3);
        expect_frame(16'hBEEF, 16'hCAFE);
        expect_frame(16'h1234, 16'h1111);
        expect_frame(16'h8001, 16'h2222);
        expect_frame(16'h7FFE, 16'h3333);
        slave_prime();
        host_write(16'hBEEF);
        host_write(16'h1234);
        host_write(16'h8001);
        host_write(16'h7FFE);
        wait_frames(4, "R2");
        tick();
        host_read(rd);
        chk(rd == 16'hCAFE, "R4", "rx word len16", rd, 16'hCAFE);

        // Test D: cpol1 cpha0, 8 bits, divider 3, batch of two, read between frames
        configure(1'b1, 1'b0, 8, 3, 1);
        expect_frame(16'h015A, 16'h0081);
        expect_frame(16'h00C3, 16'h007E);
        slave_prime();
        host_write(16'h015A);
        host_write(16'h00C3);
        wait_frames(1, "R2");
        host_read(rd);
        chk(rd == 16'h0081, "R4", "rx word cpol1 cpha0 first", rd, 16'h0081);
        wait_frames(1, "R2");
        tick();
        host_read(rd);
        chk(rd == 16'h007E, "R7", "captured after read freed it", rd, 16'h007E);
        chk(sclk == 1'b1, "R5", "idle after frame cpol1", sclk, 1);
        chk(exp_q.size() == 0, "R3", "all expected words seen", exp_q.size(), 0);

        summary();
    end

endmodule